// File: doc/BRIEF.md
# Frame-Synchronised Window Register Bank

This block keeps every per-window configuration word in two copies. Software writes a working copy through a simple register port. The display pipeline reads a live copy. The live copy is loaded from the working copy only on a vsync pulse, which is the instant the pixel fetch restarts. As a result, a frame never starts with half of a reconfiguration in place.

Each window has a protect bit. While the bit is set, none of that window's words move to the live copy at vsync. Software can set the bit, write several words, and clear the bit. All of the new values then become live together at the next vsync. Each window also has a channel-enable bit, which is frame-synchronised and protect-gated in the same way. A main control word, holding the video enable in bit 0 and the pixel clock divider in bits 8:1, is also frame-synchronised, but no protect bit gates it. A build parameter replaces the per-window protect bits with one protect bit that covers every window.

Reads on the register port return the working copy. A separate debug port returns the live copy at any address.

Top module: `vsync_shadow_bank`

## Requirements
- R1: Reset clears all working words, all live words, the main control word in both copies, all protect bits and all channel-enable bits. Every read on either port then returns 0.
- R2: A write to address w*4+r (window w in 0..4, word r in 0..3) changes the working word that the register port reads from the next cycle on. The live word that the debug port reads at the same address does not change until a vsync.
- R3: On a clock edge with vsync high, every window whose effective protect is 0 copies its four working words, and its channel-enable bit, into the live copy.
- R4: On a vsync, a window whose effective protect is 1 keeps all four live words and its live channel-enable bit unchanged.
- R5: After protect is cleared, the values written while the window was protected stay off the live copy until the next vsync. At that vsync they all become live together.
- R6: The main control word at address 20 copies to `live_main` on every vsync, whatever the protect bits hold. Without a vsync, `live_main` holds its value.
- R7: The control word at address 21 holds the protect bits in bits 4:0 (bit w is window w) and the working channel-enable bits in bits 9:5. Protect takes effect on the first vsync after the write. `live_chan` shows the live channel enables. At address 21, the debug port returns the live channel enables in bits 9:5 and the protect bits in bits 4:0.
- R8: When a working word is written in the same cycle as a vsync, the live copy takes the old working value. The working copy keeps the new value.
- R9: With GLOBAL_PROTECT=1, only bit 0 of the protect field is stored. It protects all five windows, and protect bits 4:1 read back as 0.
- R10: Writes to addresses 22 through 31 change nothing. Both ports read 0 at those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Frame-synchronisation pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Working-copy read address |
| rd_data | output | 32 | Working-copy read data (combinational) |
| dbg_addr | input | 5 | Live-copy read address |
| dbg_data | output | 32 | Live-copy read data (combinational) |
| live_main | output | 32 | Live main control word |
| live_chan | output | 5 | Live channel-enable bits |

## Verification
The bench protects each window in turn and rewrites every word, then checks that exactly the unprotected windows move at vsync. A design that decodes the protect index wrongly would update the wrong window, or would leave a protected window open to a torn update. The bench checks that a protect release alone changes nothing until the following vsync, and that a write landing on the vsync edge leaves the live copy with the previous value. A design that forwarded the write data would break both checks. A second instance built in global mode runs in parallel on the same stimulus, which shows whether one bit really covers all windows and whether the unused protect bits read as zero. A sweep over the whole address space catches stray decodes from the unused addresses.

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank #(
  parameter int NWIN = 5,
  parameter int NREG = 4,
  parameter int DW = 32,
  parameter int GLOBAL_PROTECT = 0,
  localparam int NWR = NWIN * NREG,
  localparam int MAIN_A = NWR,
  localparam int PROT_A = NWR + 1,
  localparam int AW = $clog2(NWR + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vsync,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [AW-1:0]   dbg_addr,
  output logic [DW-1:0]   dbg_data,
  output logic [DW-1:0]   live_main,
  output logic [NWIN-1:0] live_chan
);
  localparam logic [NWIN-1:0] PMASK = (GLOBAL_PROTECT != 0) ? NWIN'(1) : {NWIN{1'b1}};

  logic [DW-1:0]   work_q [NWR];
  logic [DW-1:0]   live_q [NWR];
  logic [DW-1:0]   main_work;
  logic [NWIN-1:0] prot_q, chan_work, eff_prot;

  generate
    if (GLOBAL_PROTECT != 0) begin : g_global
      assign eff_prot = {NWIN{prot_q[0]}};
    end else begin : g_per_win
      assign eff_prot = prot_q;
    end
  endgenerate

  wire wr_main = wr_en && (wr_addr == AW'(MAIN_A));
  wire wr_prot = wr_en && (wr_addr == AW'(PROT_A));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWR; i++) begin
        work_q[i] <= '0;
        live_q[i] <= '0;
      end
      main_work <= '0;
      live_main <= '0;
      prot_q    <= '0;
      chan_work <= '0;
      live_chan <= '0;
    end else begin
      for (int i = 0; i < NWR; i++) begin
        if (wr_en && wr_addr == AW'(i)) work_q[i] <= wr_data;
        if (vsync && !eff_prot[i / NREG]) live_q[i] <= work_q[i];
      end
      if (wr_main) main_work <= wr_data;
      if (vsync) live_main <= main_work;
      if (wr_prot) begin
        prot_q    <= wr_data[NWIN-1:0] & PMASK;
        chan_work <= wr_data[2*NWIN-1:NWIN];
      end
      if (vsync) live_chan <= (live_chan & eff_prot) | (chan_work & ~eff_prot);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NWR))         rd_data = work_q[rd_addr];
    else if (rd_addr == AW'(MAIN_A)) rd_data = main_work;
    else if (rd_addr == AW'(PROT_A)) rd_data = {{(DW-2*NWIN){1'b0}}, chan_work, prot_q};
  end

  always_comb begin
    dbg_data = '0;
    if (dbg_addr < AW'(NWR))         dbg_data = live_q[dbg_addr];
    else if (dbg_addr == AW'(MAIN_A)) dbg_data = live_main;
    else if (dbg_addr == AW'(PROT_A)) dbg_data = {{(DW-2*NWIN){1'b0}}, live_chan, prot_q};
  end
endmodule

// File: rtl/vsync_shadow_bank_chk.sv
module vsync_shadow_bank_chk #(
  parameter int NWIN = 5,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vsync,
  input logic [DW-1:0]   main_work,
  input logic [DW-1:0]   live_main,
  input logic [NWIN-1:0] eff_prot,
  input logic [NWIN-1:0] chan_work,
  input logic [NWIN-1:0] live_chan
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (live_main == '0 && live_chan == '0));

  // R6
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(live_main));

  // R6
  main_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> live_main == $past(main_work));

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    // R3
    chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !eff_prot[w]) |=> live_chan[w] == $past(chan_work[w]));

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eff_prot[w] |=> $stable(live_chan[w]));
  end
endmodule

bind vsync_shadow_bank vsync_shadow_bank_chk #(.NWIN(NWIN), .DW(DW)) chk (.*);

// File: tb/vsync_shadow_bank_test.sv
module vsync_shadow_bank_test;
  logic clk = 0;
  logic rst_n = 0;
  logic vsync = 0, wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0, dbg_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_p, dbg_p, lm_p, rd_g, dbg_g, lm_g;
  logic [4:0] lc_p, lc_g;

  always #10 clk = ~clk;

  vsync_shadow_bank uut (.clk, .rst_n, .vsync, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data(rd_p), .dbg_addr, .dbg_data(dbg_p),
    .live_main(lm_p), .live_chan(lc_p));

  vsync_shadow_bank #(.GLOBAL_PROTECT(1)) uut_g (.clk, .rst_n, .vsync, .wr_en,
    .wr_addr, .wr_data, .rd_addr, .rd_data(rd_g), .dbg_addr,
    .dbg_data(dbg_g), .live_main(lm_g), .live_chan(lc_g));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] mw [2][21];
  logic [31:0] ml [2][21];
  logic [4:0]  prot [2], chw [2], chl [2];

  function automatic bit effp(int m, int w);
    return (m == 1) ? prot[m][0] : prot[m][w];
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    for (int m = 0; m < 2; m++) begin
      if (a <= 20) mw[m][a] = d;
      if (a == 21) begin
        prot[m] = (m == 1) ? (d[4:0] & 5'b00001) : d[4:0];
        chw[m] = d[9:5];
      end
    end
  endtask

  task automatic model_vsync();
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 20; a++)
        if (!effp(m, a / 4)) ml[m][a] = mw[m][a];
      ml[m][20] = mw[m][20];
      for (int w = 0; w < 5; w++)
        if (!effp(m, w)) chl[m][w] = chw[m][w];
    end
  endtask

  function automatic logic [31:0] exp_rd(int m, int a);
    if (a <= 20) return mw[m][a];
    if (a == 21) return {22'b0, chw[m], prot[m]};
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_dbg(int m, int a);
    if (a <= 20) return ml[m][a];
    if (a == 21) return {22'b0, chl[m], prot[m]};
    return 32'h0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 32; a++) begin
      rd_addr = a[4:0];
      dbg_addr = a[4:0];
      #1;
      chk(tag, $sformatf("rd[%0d] per-window", a), rd_p, exp_rd(0, a));
      chk(tag, $sformatf("dbg[%0d] per-window", a), dbg_p, exp_dbg(0, a));
      chk(tag, $sformatf("rd[%0d] global", a), rd_g, exp_rd(1, a));
      chk(tag, $sformatf("dbg[%0d] global", a), dbg_g, exp_dbg(1, a));
    end
    chk(tag, "live_main per-window", lm_p, ml[0][20]);
    chk(tag, "live_main global", lm_g, ml[1][20]);
    chk(tag, "live_chan per-window", {27'b0, lc_p}, {27'b0, chl[0]});
    chk(tag, "live_chan global", {27'b0, lc_g}, {27'b0, chl[1]});
  endtask

  task automatic wr(int a, logic [31:0] d, bit vs);
    @(negedge clk);
    wr_en = 1; wr_addr = a[4:0]; wr_data = d; vsync = vs;
    if (vs) model_vsync();
    model_write(a, d);
    @(negedge clk);
    wr_en = 0; vsync = 0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk);
    vsync = 1;
    model_vsync();
    @(negedge clk);
    vsync = 0;
  endtask

  task automatic fill(logic [31:0] seed);
    for (int a = 0; a < 20; a++) wr(a, seed ^ (a * 32'h0101_0011), 0);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 21; a++) begin mw[m][a] = 0; ml[m][a] = 0; end
      prot[m] = 0; chw[m] = 0; chl[m] = 0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    check_all("R1");

    fill(32'hA500_0000);
    check_all("R2");
    pulse_vsync();
    check_all("R3");

    wr(21, {22'b0, 5'b11111, 5'b01010}, 0);
    check_all("R7");
    fill(32'h3C00_1000);
    pulse_vsync();
    check_all("R4");

    wr(20, 32'h0000_01FF, 0);
    check_all("R6");
    pulse_vsync();
    check_all("R6");

    wr(21, {22'b0, 5'b11111, 5'b00000}, 0);
    check_all("R5");
    pulse_vsync();
    check_all("R5");

    for (int w = 0; w < 5; w++) begin
      wr(21, {22'b0, 5'(w * 7 + 3), 5'(1 << w)}, 0);
      fill(32'h7700_0000 + w);
      wr(20, 32'h100 + w, 0);
      pulse_vsync();
      check_all("R4");
    end

    wr(21, {22'b0, 5'b00110, 5'b00101}, 0);
    fill(32'h5A5A_0000);
    pulse_vsync();
    check_all("R9");

    wr(21, 32'h0, 0);
    pulse_vsync();
    wr(3, 32'hDEAD_BEEF, 1);
    wr(20, 32'h0000_0042, 1);
    check_all("R8");
    pulse_vsync();
    check_all("R8");

    wr(22, 32'hFFFF_FFFF, 0);
    wr(27, 32'h1234_5678, 1);
    wr(31, 32'hCAFE_F00D, 0);
    check_all("R10");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule